// File: doc/BRIEF.md
# Single-Precision Multiplier on Shared Parallel Buses

This block multiplies two 32-bit binary floating-point operands and returns a 32-bit product. It sits on shared parallel buses. The two operand buses are sampled under an active-low capture strobe, and the product is placed on a three-state result bus only while a separate active-low output strobe is held low. At all other times the block leaves the result bus undriven, so other agents may use it.

Every operand class is accepted and can also be produced: NaN, signed infinity, signed zero, normals and denormals. Special operands are resolved by a fixed priority. Ordinary operands go through a significand multiply, normalization and rounding to nearest with ties to even. Rounding handles both gradual underflow into the denormal range and overflow to infinity.

All logic runs on one clock. The strobes are sampled on that clock. The product is registered one cycle after capture, well ahead of the moment the output strobe falls in a normal bus cycle.

Top module: `fp_bus_mul`

## Requirements
- R1: A word is decoded as sign (bit 31), biased exponent (bits 30..23) and fraction (bits 22..0). Exponent 255 with a nonzero fraction is NaN whatever the sign. Exponent 255 with a zero fraction is infinity. Exponent 0 with a zero fraction is zero. Exponent 0 with a nonzero fraction is a denormal of value 0.f x 2^-126. Any other exponent gives a normal of value 1.f x 2^(e-127).
- R2: Special operands resolve in this priority order. First, any NaN operand gives NaN. Next, infinity times zero (either order, any signs) gives NaN. Next, any infinity gives infinity. Next, any zero gives zero. Only then is the numeric product formed.
- R3: Every NaN result is the word 0x7F800001.
- R4: An infinity, zero or numeric result carries the XOR of the two operand signs.
- R5: Operands are taken from a_i and b_i at the first clock edge that samples latch_ni high after it was sampled low. Bus values at any other time have no effect. The product of the latest captured pair is present on c_o, when driven, from the second rising edge after that capture edge.
- R6: c_o carries the product while drive_ni is low and rst_ni is high. Otherwise every bit of c_o is high impedance, and this includes the whole reset period. After reset with no capture, the held result is +0 (0x00000000). The driven value stays constant through a drive window when no capture occurs.
- R7: Normal-range products are rounded to nearest, ties to even, using the guard bit, the round bit and the sticky OR of all lower bits. A rounding carry out of the significand renormalizes and increments the exponent.
- R8: Denormal operands give exact products. They are normalized internally before the multiply.
- R9: Products below 2^-126 are returned as correctly rounded denormals, including the largest denormal 0x007FFFFF. A denormal that rounds up to 2^-126, and an exact product of 2^-126, both give 0x00800000 (exponent field 1).
- R10: A product whose rounded magnitude reaches 2^128 or more gives infinity with the product sign.
- R11: A product too small for the least denormal after rounding gives zero with the product sign. A product above half the least denormal rounds up to it (0x00000001), and exactly half rounds to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| latch_ni | input | 1 | Operand capture strobe, active low; capture on its return high |
| drive_ni | input | 1 | Result bus enable, active low |
| a_i | input | 32 | Operand A bus |
| b_i | input | 32 | Operand B bus |
| c_o | output | 32 | Three-state result bus |

## Verification
The hardest outcomes to reach from the ports are the rounding boundaries. These are ties that must go to the even neighbour, a denormal product that must round up across into exponent field 1, and sub-denormal products sitting at or just above half of the least denormal. Random operands almost never land on these. The stimulus therefore uses operand pairs chosen so that the exact product puts a known pattern on the guard, round and sticky bits: 1.5, 1.25 and 1.75 times 1+k*2^-23, the largest denormal times 1+2^-23, and the least denormal times 0.5 and 0.75. The bus itself is weakly pulled high in the bench. A released c_o therefore reads as all ones, a word the block never drives.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int EI_W   = EXP_W + 3;
  localparam int LZ_W   = $clog2(SIG_W + 1);
  localparam int SH_W   = $clog2(PROD_W + 1);
  localparam int GRD    = PROD_W - SIG_W - 1;

  localparam logic [WORD_W-1:0] QNAN_WORD =
    {1'b0, {EXP_W{1'b1}}, {(FRAC_W-1){1'b0}}, 1'b1};
  localparam logic [WORD_W-2:0] INF_MAG = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  typedef enum logic [2:0] {
    FC_ZERO, FC_DENORM, FC_NORM, FC_INF, FC_NAN
  } fp_class_e;

  // sig has its msb set for nonzero finite values; value = sig * 2^(exp-BIAS-FRAC_W)
  typedef struct packed {
    logic                   sign;
    fp_class_e              cls;
    logic signed [EI_W-1:0] exp;
    logic [SIG_W-1:0]       sig;
  } fp_unp_t;
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
  import fpm_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output fp_unp_t           unp_o
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_zero, exp_full, frac_zero;
  logic [SIG_W-1:0]  sig_raw;
  logic [LZ_W-1:0]   lz;
  logic              hit;

  assign exp_f     = word_i[WORD_W-2 -: EXP_W];
  assign frac_f    = word_i[FRAC_W-1:0];
  assign exp_zero  = (exp_f == '0);
  assign exp_full  = (exp_f == {EXP_W{1'b1}});
  assign frac_zero = (frac_f == '0);
  assign sig_raw   = {~exp_zero, frac_f};

  always_comb begin
    lz  = '0;
    hit = 1'b0;
    for (int i = SIG_W - 1; i >= 0; i--) begin
      if (!hit) begin
        if (sig_raw[i]) hit = 1'b1;
        else            lz  = lz + LZ_W'(1);
      end
    end
  end

  always_comb begin
    unp_o.sign = word_i[WORD_W-1];
    if (exp_full)      unp_o.cls = frac_zero ? FC_INF  : FC_NAN;
    else if (exp_zero) unp_o.cls = frac_zero ? FC_ZERO : FC_DENORM;
    else               unp_o.cls = FC_NORM;
    // denormals: shift out leading zeros, compensate in the exponent
    unp_o.exp = exp_zero ? (EI_W'(1) - EI_W'(lz)) : EI_W'(exp_f);
    unp_o.sig = sig_raw << lz;
  end
endmodule

// File: rtl/fpm_round_pack.sv
module fpm_round_pack
  import fpm_pkg::*;
(
  input  logic signed [EI_W-1:0] exp_i,
  input  logic [PROD_W-1:0]      norm_i,
  output logic [WORD_W-2:0]      mag_o
);
  logic                   denorm, ovf;
  logic signed [EI_W-1:0] sh_full;
  logic [SH_W-1:0]        sh;
  logic [PROD_W-1:0]      shifted, lost;
  logic [SIG_W-1:0]       kept;
  logic                   g_bit, r_bit, s_bit, up;
  logic [SIG_W:0]         rnd;
  logic [EXP_W-1:0]       base;

  assign denorm  = (exp_i < 1);
  assign ovf     = (exp_i >= EXP_MAX);
  assign sh_full = EI_W'(1) - exp_i;

  always_comb begin
    if (!denorm)                       sh = '0;
    else if (sh_full > EI_W'(PROD_W))  sh = SH_W'(PROD_W);
    else                               sh = SH_W'(sh_full);
  end

  assign shifted = norm_i >> sh;
  assign lost    = norm_i & ~({PROD_W{1'b1}} << sh);
  assign kept    = shifted[PROD_W-1 -: SIG_W];
  assign g_bit   = shifted[GRD];
  assign r_bit   = shifted[GRD-1];
  assign s_bit   = (|shifted[GRD-2:0]) | (|lost);
  assign up      = g_bit & (r_bit | s_bit | kept[0]);
  assign rnd     = {1'b0, kept} + (SIG_W+1)'(up);
  assign base    = denorm ? '0 : EXP_W'(exp_i - EI_W'(1));

  // hidden bit and rounding carry both ripple into the exponent field
  assign mag_o = ovf ? INF_MAG
                     : ({base, {FRAC_W{1'b0}}} + (WORD_W-1)'(rnd));
endmodule

// File: rtl/fpm_core.sv
module fpm_core
  import fpm_pkg::*;
(
  input  fp_unp_t           a_i,
  input  fp_unp_t           b_i,
  output logic [WORD_W-1:0] res_o
);
  logic                   sign;
  logic [PROD_W-1:0]      prod, norm;
  logic                   top;
  logic signed [EI_W-1:0] exp_n;
  logic [WORD_W-2:0]      mag;
  logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;

  assign sign  = a_i.sign ^ b_i.sign;
  assign prod  = a_i.sig * b_i.sig;
  assign top   = prod[PROD_W-1];
  assign norm  = top ? prod : (prod << 1);
  assign exp_n = a_i.exp + b_i.exp - EI_W'(BIAS) + EI_W'(top);

  fpm_round_pack i_round (
    .exp_i  (exp_n),
    .norm_i (norm),
    .mag_o  (mag)
  );

  assign a_nan  = (a_i.cls == FC_NAN);
  assign b_nan  = (b_i.cls == FC_NAN);
  assign a_inf  = (a_i.cls == FC_INF);
  assign b_inf  = (b_i.cls == FC_INF);
  assign a_zero = (a_i.cls == FC_ZERO);
  assign b_zero = (b_i.cls == FC_ZERO);

  always_comb begin
    if (a_nan || b_nan)                             res_o = QNAN_WORD;
    else if ((a_inf && b_zero) || (a_zero && b_inf)) res_o = QNAN_WORD;
    else if (a_inf || b_inf)                        res_o = {sign, INF_MAG};
    else if (a_zero || b_zero)                      res_o = {sign, {(WORD_W-1){1'b0}}};
    else                                            res_o = {sign, mag};
  end
endmodule

// File: rtl/fp_bus_mul.sv
module fp_bus_mul
  import fpm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_ni,
  input  logic              drive_ni,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] c_o
);
  localparam int N_OPS = 2;

  logic              latch_q;
  logic              capture;
  logic [WORD_W-1:0] op_a_q, op_b_q, res_d, res_q;
  logic [WORD_W-1:0] op_w [N_OPS];
  fp_unp_t           unp  [N_OPS];

  assign capture = latch_ni & ~latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= 1'b1;
      op_a_q  <= '0;
      op_b_q  <= '0;
      res_q   <= '0;
    end else begin
      latch_q <= latch_ni;
      res_q   <= res_d;
      if (capture) begin
        op_a_q <= a_i;
        op_b_q <= b_i;
      end
    end
  end

  assign op_w[0] = op_a_q;
  assign op_w[1] = op_b_q;

  for (genvar k = 0; k < N_OPS; k++) begin : g_unp
    fpm_unpack i_unpack (
      .word_i (op_w[k]),
      .unp_o  (unp[k])
    );
  end

  fpm_core i_core (
    .a_i   (unp[0]),
    .b_i   (unp[1]),
    .res_o (res_d)
  );

  assign c_o = (rst_ni && !drive_ni) ? res_q : {WORD_W{1'bz}};
endmodule

// File: rtl/fpm_mul_chk.sv
module fpm_mul_chk
  import fpm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              latch_ni,
  input logic [WORD_W-1:0] op_a_q,
  input logic [WORD_W-1:0] op_b_q,
  input logic [WORD_W-1:0] res_q
);
  logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;

  assign a_nan  = (op_a_q[30:23] == 8'hFF) && (op_a_q[22:0] != '0);
  assign b_nan  = (op_b_q[30:23] == 8'hFF) && (op_b_q[22:0] != '0);
  assign a_inf  = (op_a_q[30:23] == 8'hFF) && (op_a_q[22:0] == '0);
  assign b_inf  = (op_b_q[30:23] == 8'hFF) && (op_b_q[22:0] == '0);
  assign a_zero = (op_a_q[30:0] == '0);
  assign b_zero = (op_b_q[30:0] == '0);

  // R5
  capture_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(latch_ni) |=> ($stable(op_a_q) && $stable(op_b_q)));

  // R5
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(op_a_q) && $stable(op_b_q)) |=> $stable(res_q));

  // R3
  nan_canon_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((res_q[30:23] == 8'hFF) && (res_q[22:0] != '0)) |-> (res_q == QNAN_WORD));

  // R4
  sign_xor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!a_nan && !b_nan && !(a_inf && b_zero) && !(a_zero && b_inf))
      |=> (res_q[31] == $past(op_a_q[31] ^ op_b_q[31])));

  // R2
  zero_operand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((a_zero && !b_nan && !b_inf) || (b_zero && !a_nan && !a_inf))
      |=> (res_q[30:0] == '0));

  // R2
  nan_operand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_nan || b_nan) |=> (res_q == QNAN_WORD));
endmodule

bind fp_bus_mul fpm_mul_chk i_fpm_mul_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .latch_ni (latch_ni),
  .op_a_q   (op_a_q),
  .op_b_q   (op_b_q),
  .res_q    (res_q)
);

// File: tb/test_fp_bus_mul.sv
module test_fp_bus_mul;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 28;
  localparam logic [31:0] RELEASED = 32'hFFFF_FFFF;  // weak pull-up reading

  // {a, b, expected}
  localparam logic [95:0] VEC [N_VEC] = '{
    {32'h3F800000, 32'h3F800000, 32'h3F800000},  // R7 1*1
    {32'h41C80000, 32'h41C80000, 32'h441C4000},  // R7 25*25
    {32'h41C80000, 32'hC1C80000, 32'hC41C4000},  // R4 25*-25
    {32'h41C80000, 32'h42C80000, 32'h451C4000},  // R7 25*100
    {32'h41C80000, 32'h3C23D70A, 32'h3E800000},  // R7 25*0.01 rounds up
    {32'h41C80000, 32'h00280000, 32'h01FA0000},  // R8 denormal operand
    {32'hC1C80000, 32'h7F800001, 32'h7F800001},  // R3 NaN operand
    {32'hC1C80000, 32'hFF800000, 32'h7F800000},  // R4 -25*-inf
    {32'hC1C80000, 32'h7F800000, 32'hFF800000},  // R4 -25*+inf
    {32'hC1C80000, 32'h80000000, 32'h00000000},  // R4 -25*-0
    {32'h7F800000, 32'h80000000, 32'h7F800001},  // R2 inf*zero
    {32'hFFC00000, 32'h00000000, 32'h7F800001},  // R1 negative NaN
    {32'hFF800000, 32'h7FFFFFFF, 32'h7F800001},  // R2 NaN beats inf
    {32'h00000001, 32'h7F800000, 32'h7F800000},  // R2 denormal*inf
    {32'h3FC00000, 32'h3F800001, 32'h3FC00002},  // R7 tie, odd -> up
    {32'h3FC00000, 32'h3F800003, 32'h3FC00004},  // R7 tie, even -> stay
    {32'h3FE00000, 32'h3F800001, 32'h3FE00002},  // R7 guard and round
    {32'h3FA00000, 32'h3F800001, 32'h3FA00001},  // R7 guard clear
    {32'h00800000, 32'h3F000000, 32'h00400000},  // R9 into denormal
    {32'h007FFFFF, 32'h3F800000, 32'h007FFFFF},  // R9 largest denormal
    {32'h00400000, 32'h40000000, 32'h00800000},  // R9 exact min normal
    {32'h007FFFFF, 32'h3F800001, 32'h00800000},  // R9 rounds to min normal
    {32'h7F000000, 32'h40000000, 32'h7F800000},  // R10 overflow
    {32'hFF7FFFFF, 32'h3F800001, 32'hFF800000},  // R10 negative overflow
    {32'h00000001, 32'h00000001, 32'h00000000},  // R11 deep underflow
    {32'h80000001, 32'h00000001, 32'h80000000},  // R11 signed underflow
    {32'h00000001, 32'h3F400000, 32'h00000001},  // R11 above half
    {32'h00000001, 32'h3F000000, 32'h00000000}   // R11 exact half
  };
  localparam int VEC_REQ [N_VEC] = '{7, 7, 4, 7, 7, 8, 3, 4, 4, 4, 2, 1, 2, 2,
                                     7, 7, 7, 7, 9, 9, 9, 9, 10, 10, 11, 11, 11, 11};

  logic        clk = 1'b0;
  logic        rst_ni, latch_ni, drive_ni;
  logic [31:0] a_i, b_i;
  wire  [31:0] c_bus;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar k = 0; k < 32; k++) begin : g_pull
    pullup pu (c_bus[k]);
  end

  fp_bus_mul i_fp_bus_mul (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .latch_ni (latch_ni),
    .drive_ni (drive_ni),
    .a_i      (a_i),
    .b_i      (b_i),
    .c_o      (c_bus)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic latch_ops(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk); a_i = a; b_i = b; latch_ni = 1'b0;
    @(negedge clk);
    @(negedge clk); latch_ni = 1'b1;
    @(negedge clk); a_i = 32'hDEAD_BEEF; b_i = 32'h1234_5678;
  endtask

  task automatic read_bus(input logic [31:0] exp, input string tag);
    @(negedge clk); drive_ni = 1'b0;
    @(posedge clk); #2; check(c_bus, exp, tag);
    @(posedge clk); #2; check(c_bus, exp, {tag, " held (R6)"});
    @(negedge clk); drive_ni = 1'b1;
    @(posedge clk); #2; check(c_bus, RELEASED, {tag, " release R6"});
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; latch_ni = 1'b1; drive_ni = 1'b0;
    a_i = 32'h3F800000; b_i = 32'h3F800000;
    repeat (3) @(negedge clk);
    #1 check(c_bus, RELEASED, "R6 bus undriven in reset");
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #2; check(c_bus, 32'h0, "R6 reset result");
    @(negedge clk); drive_ni = 1'b1;
    @(posedge clk); #2; check(c_bus, RELEASED, "R6 drive high releases");

    for (int i = 0; i < N_VEC; i++) begin
      latch_ops(VEC[i][95:64], VEC[i][63:32]);
      read_bus(VEC[i][31:0], $sformatf("R%0d vector %0d", VEC_REQ[i], i));
    end

    // R5 bus traffic while latch high is ignored
    latch_ops(32'h3F800000, 32'h40400000);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); a_i = 32'h7F800000 + i; b_i = 32'h0000_0000;
    end
    read_bus(32'h40400000, "R5 ignore bus while idle");

    // R5 only the value present at the rising edge counts
    @(negedge clk); a_i = 32'h7F800000; b_i = 32'h00000000; latch_ni = 1'b0;
    @(negedge clk); a_i = 32'h40000000; b_i = 32'h40000000;
    @(negedge clk); latch_ni = 1'b1;
    @(negedge clk); a_i = 32'hFFFF_0000; b_i = 32'h0;
    read_bus(32'h40800000, "R5 last value at rise");

    // R6 second drive window without capture shows same value
    read_bus(32'h40800000, "R6 repeat drive");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule